// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block conditions one external non-maskable interrupt line before it reaches a main interrupt controller. The asynchronous input pin passes through a synchronizer. A detector then applies one of four trigger conditions chosen by software: active-low level, falling edge, active-high level or rising edge. A detected condition latches a pending flag, and an enable bit gates that flag onto a registered interrupt output.

Software reaches three registers through a plain single-cycle register port: address, write strobe, write data and combinational read data. The control register holds the trigger mode in its two lowest bits and keeps every other bit that is written to it. The pending register is cleared by writing one to bit 0. The enable register sits at one of two offsets, selected by a parameter, so that the same RTL serves both address maps.

In level modes the flag sets again every cycle while the pin stays active. The service routine must therefore clear pending only after the source has gone idle, or it sees a second interrupt when it unmasks.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset, the control register reads 0 (active-low level mode), the enable register reads 0, the pending register reads 0 while the pin is high, and `irq_o` is 0.
- R2: The control register is at offset 0x00. Its bits [1:0] select the trigger: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. All `DATA_W` written bits read back unchanged.
- R3: In level modes (0 = pin low, 2 = pin high) pending is set while the synchronized pin is at its active level. A clear written while it stays active leaves pending at 1.
- R4: In edge modes (1 = high-to-low, 3 = low-to-high) pending is set by a transition in the selected direction only. It stays 1 after the pin returns to idle, until software clears it.
- R5: The pending register is at offset 0x04 and reads pending in bit 0, with all other bits 0. A write with bit 0 = 1 clears pending. A write with bit 0 = 0 has no effect.
- R6: When a clear write and a trigger event occur in the same cycle, pending ends at 1.
- R7: Bit 0 of the enable register is at offset 0x08 when `ALT_ENABLE_MAP` = 0 and at offset 0x34 when it is 1. `irq_o` equals pending AND enable as they stood before the previous clock edge, so it follows an enable write one cycle after the enable register changes.
- R8: Reads of any offset other than the three mapped ones return 0, and writes to them change no register.
- R9: Rewriting the trigger mode while the pin is steady never sets pending by itself, including a switch between the two edge directions.
- R10: A pin change reaches pending on the third rising clock edge after it, through a two-stage synchronizer, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request to the main controller |

## Verification
The bench steps a vector table through every trigger mode with pins that do and do not match it. Skipping the level re-assertion would show pending dropping after a clear while the pin is still active. A detector that is blind to direction would latch on the opposite edge. Directed tests line a clear write up with an edge on the exact same clock edge, where a clear-wins priority loses the event. They also flip the edge direction with the pin steady, where a detector that keeps its previous sample in the old polarity reports a false edge. Further tests count the synchronizer latency one edge at a time, check the one-cycle lag of the interrupt output after an enable write, and address unmapped offsets and the second enable location, where a loose decoder would alias or leak data.

// File: rtl/nmi_pkg.sv
`timescale 1ns/1ps
package nmi_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'd0,
        TRIG_FALL   = 2'd1,
        TRIG_LVL_HI = 2'd2,
        TRIG_RISE   = 2'd3
    } trig_e;

    localparam int unsigned CTRL_OFS   = 32'h00;
    localparam int unsigned PEND_OFS   = 32'h04;
    localparam int unsigned EN_OFS_STD = 32'h08;
    localparam int unsigned EN_OFS_ALT = 32'h34;

    // Edge modes have bit 0 set.
    function automatic logic trig_is_edge(input trig_e t);
        return t[0];
    endfunction

    // Low-active modes (low level, falling edge) have bit 1 clear.
    function automatic logic trig_inverts(input trig_e t);
        return ~t[1];
    endfunction

    function automatic int unsigned enable_offset(input bit alt);
        return alt ? EN_OFS_ALT : EN_OFS_STD;
    endfunction

endpackage

// File: rtl/nmi_sync.sv
`timescale 1ns/1ps
module nmi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_VAL;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
`timescale 1ns/1ps
module nmi_detect
    import nmi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_s,
    input  trig_e mode,
    output logic  evt_o
);
    // The pin is normalized so that 1 means "active" in the current mode.
    logic  act;
    logic  prev_act_q;
    trig_e mode_q;
    logic  mode_chg;
    logic  edge_hit;

    assign act      = pin_s ^ trig_inverts(mode);
    assign mode_chg = (mode != mode_q);
    // The previous sample was normalized under the old mode: suppress edges for one cycle.
    assign edge_hit = act & ~prev_act_q & ~mode_chg;
    assign evt_o    = trig_is_edge(mode) ? edge_hit : act;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act_q <= 1'b0;
            mode_q     <= TRIG_LVL_LO;
        end else begin
            prev_act_q <= act;
            mode_q     <= mode;
        end
    end
endmodule

// File: rtl/nmi_regs.sv
`timescale 1ns/1ps
module nmi_regs
    import nmi_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter int unsigned EN_OFS = EN_OFS_STD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_i,
    output trig_e             mode_o,
    output logic              pend_o,
    output logic              en_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

    logic [DATA_W-1:0] ctrl_q;
    logic              pend_q;
    logic              en_q;
    logic              sel_ctrl, sel_pend, sel_en;
    logic              pend_clr;

    assign sel_ctrl = (bus_addr == A_CTRL);
    assign sel_pend = (bus_addr == A_PEND);
    assign sel_en   = (bus_addr == A_EN);
    assign pend_clr = bus_we & sel_pend & bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (bus_we && sel_ctrl) ctrl_q <= bus_wdata;
            if (bus_we && sel_en)   en_q   <= bus_wdata[0];
            // A new event wins over a simultaneous clear.
            pend_q <= evt_i | (pend_q & ~pend_clr);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata    = ctrl_q;
        else if (sel_pend) bus_rdata[0] = pend_q;
        else if (sel_en)   bus_rdata[0] = en_q;
    end

    assign mode_o = trig_e'(ctrl_q[1:0]);
    assign pend_o = pend_q;
    assign en_o   = en_q;
endmodule

// File: rtl/nmi_line_ctrl.sv
`timescale 1ns/1ps
module nmi_line_ctrl
    import nmi_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter bit ALT_ENABLE_MAP = 1'b0,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int unsigned EN_OFS = enable_offset(ALT_ENABLE_MAP);

    logic  pin_s;
    trig_e trig_mode;
    logic  trig_evt;
    logic  pend_q;
    logic  en_q;
    logic  irq_q;

    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    nmi_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .pin_s (pin_s),
        .mode  (trig_mode),
        .evt_o (trig_evt)
    );

    nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFS(EN_OFS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (trig_evt),
        .mode_o    (trig_mode),
        .pend_o    (pend_q),
        .en_o      (en_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend_q & en_q;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/nmi_line_ctrl_chk.sv
`timescale 1ns/1ps
module nmi_line_ctrl_chk #(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter int unsigned EN_OFS = 32'h08
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              clr_bit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              pend,
    input logic              en,
    input logic              evt
);
    logic clr_wr;
    logic mapped;

    assign clr_wr = bus_we && (bus_addr == ADDR_W'(32'h04)) && clr_bit;
    assign mapped = (bus_addr == ADDR_W'(32'h00)) || (bus_addr == ADDR_W'(32'h04))
                 || (bus_addr == ADDR_W'(EN_OFS));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !evt) |=> !pend);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr_wr) |=> pend);

    p_masked_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq_o);

    p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(pend));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (bus_rdata == '0));

    p_rise_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(evt));
endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EN_OFS (EN_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .clr_bit   (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pend      (pend_q),
    .en        (en_q),
    .evt       (trig_evt)
);

// File: tb/test_nmi_line_ctrl.sv
`timescale 1ns/1ps
module test_nmi_line_ctrl;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_CTRL = 8'h00;
    localparam logic [AW-1:0] A_PEND = 8'h04;
    localparam logic [AW-1:0] A_EN   = 8'h08;
    localparam logic [AW-1:0] A_ALT  = 8'h34;

    // {mode[1:0], pin_idle, pin_test, pend_after_test, pend_after_clear}
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 low level active
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 low level idle
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 high level active
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 high level idle
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 falling edge
        {2'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 rising in falling mode
        {2'd3, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 rising edge
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0}   // R4 falling in rising mode
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic [AW-1:0] a_addr = '0;
    logic          a_we = 1'b0;
    logic [DW-1:0] a_wdata = '0;
    logic [DW-1:0] a_rdata;
    logic          a_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nmi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALT_ENABLE_MAP(1'b0)) i_nmi_line_ctrl (
        .clk(clk), .rst(rst), .pin_i(pin), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    nmi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALT_ENABLE_MAP(1'b1)) i_nmi_line_ctrl_alt (
        .clk(clk), .rst(rst), .pin_i(pin), .bus_addr(a_addr), .bus_we(a_we),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq_o(a_irq)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 v = rdata;
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        clks(4);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, '0);
        rd(A_EN, v);   chk("R1 enable", v, '0);
        rd(A_PEND, v); chk("R1 pending", v, '0);
        chk("R1 irq", {31'b0, irq}, '0);

        // R3/R4 table of modes and pin patterns
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) pin = VEC[i][3];
            wr(A_CTRL, {30'b0, VEC[i][5:4]});
            clks(6);
            wr(A_PEND, 32'h1);
            clks(6);
            @(negedge clk) pin = VEC[i][2];
            clks(6);
            rd(A_PEND, v); chk("R3/R4 table set", v, {31'b0, VEC[i][1]});
            wr(A_PEND, 32'h1);
            clks(2);
            rd(A_PEND, v); chk("R3/R4 table after clear", v, {31'b0, VEC[i][0]});
        end

        // R2 all control bits retained
        wr(A_CTRL, 32'hA5C3_F00F);
        rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'hA5C3_F00F);

        // R4 edge pending stays after pin returns idle; R5 write of 0 ignored
        @(negedge clk) pin = 1'b0;
        clks(6);
        wr(A_PEND, 32'h1);
        @(negedge clk) pin = 1'b1;
        clks(6);
        @(negedge clk) pin = 1'b0;
        clks(6);
        rd(A_PEND, v); chk("R4 hold after idle", v, 32'h1);
        wr(A_PEND, 32'hFFFF_FFFE);
        rd(A_PEND, v); chk("R5 write zero ignored", v, 32'h1);

        // R7 enable/irq timing (pending is 1)
        wr(A_EN, 32'h1);
        chk("R7 irq lags enable", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq asserted", {31'b0, irq}, 32'h1);
        rd(A_EN, v); chk("R7 enable readback", v, 32'h1);
        wr(A_EN, 32'h0);
        chk("R7 irq lags disable", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R7 irq masked", {31'b0, irq}, 32'h0);

        wr(A_PEND, 32'h1);
        rd(A_PEND, v); chk("R5 clear", v, 32'h0);

        // R10 latency, rising mode, pin low
        @(negedge clk) begin addr = A_PEND; pin = 1'b1; end
        @(posedge clk); @(posedge clk);
        @(negedge clk); #1 chk("R10 not after two edges", rdata, 32'h0);
        @(posedge clk);
        @(negedge clk); #1 chk("R10 set on third edge", rdata, 32'h1);

        // R6 clear and edge on the same clock edge
        @(negedge clk) pin = 1'b0;
        clks(6);
        wr(A_PEND, 32'h1);
        @(negedge clk) pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) begin addr = A_PEND; we = 1'b1; wdata = 32'h1; end
        @(posedge clk);
        @(negedge clk) we = 1'b0;
        #1 chk("R6 set wins over clear", rdata, 32'h1);
        wr(A_PEND, 32'h1);

        // R9 mode change with steady pin
        @(negedge clk) pin = 1'b0;
        clks(6);
        wr(A_PEND, 32'h1);
        wr(A_CTRL, 32'h1);
        clks(6);
        rd(A_PEND, v); chk("R9 rising to falling, pin low", v, 32'h0);
        @(negedge clk) pin = 1'b1;
        clks(6);
        wr(A_PEND, 32'h1);
        wr(A_CTRL, 32'h3);
        clks(6);
        rd(A_PEND, v); chk("R9 falling to rising, pin high", v, 32'h0);

        // R8 unmapped offsets
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(A_ALT, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R8 unmapped read", v, 32'h0);
        rd(A_ALT, v); chk("R8 alt offset unmapped in default map", v, 32'h0);
        rd(A_CTRL, v); chk("R8 ctrl untouched", v, 32'h3);
        rd(A_EN, v);   chk("R8 enable untouched", v, 32'h0);

        // R7 alternate enable location
        @(negedge clk) begin a_addr = A_ALT; a_we = 1'b1; a_wdata = 32'h1; end
        @(negedge clk) a_we = 1'b0;
        #1 chk("R7 alt enable at 0x34", a_rdata, 32'h1);
        @(negedge clk) a_addr = A_EN;
        #1 chk("R7 alt map 0x08 unmapped", a_rdata, 32'h0);

        finish_run();
    end
endmodule